// File: doc/BRIEF.md
# Ramp-Compare Conversion Timer

This block is the digital half of a single-slope converter for a motor-control PWM system. A current source charges an external capacitor, and each of four comparators flips when the rising ramp passes its input voltage. Only the timing of those flips reaches this block. It runs one shared 12-bit counter that is held at zero while the PWM synchronisation pulse is high, which is when the capacitor is discharged. The counter climbs after the pulse ends and stops at its ceiling. For each comparator, the block stores the count at which that comparator first rose. The stored value is the conversion result for that channel.

At the start of every synchronisation pulse, the four timestamps from the cycle that just ended are copied into result registers. A channel that did not trip is copied as zero. Software therefore always reads one complete set of results from a single cycle. A small register port gives access to a rate-select bit, the four results, and a 3-bit trim code. The trim code is driven straight to the analog current source. Three main channels and one auxiliary channel are handled in the same way.

Top module: `ramp_adc_capture`

## Requirements
- R1: After reset, all four results read 0x000, the mode register reads 0, and the trim register and `trim_out` are 0.
- R2: With the rate bit set (bit 7 at address 0), the counter advances once per clock. A comparator input first sampled high on the k-th rising clock edge after `pwm_sync` is sampled low reports k+1.
- R3: With the rate bit clear, the counter advances once every two clocks. The same input reports floor((k+1)/2).
- R4: A result never exceeds 4095. The counter stops at 4095 and stays there until the next synchronisation pulse.
- R5: Only the first rising edge of a comparator input during counting is captured. Later falls and rises in the same cycle do not change the value.
- R6: A channel with no rising edge during counting reports 0x000. This includes an input that was already high when the pulse ended.
- R7: Results are published on the clock edge where `pwm_sync` is first sampled high. They do not change at any other time.
- R8: The register map is as follows. Address 0 holds the rate bit at bit 7, and every other bit reads 0. Addresses 1 to 4 are channels 0 to 3, hold the result in bits 11:0, and are read-only. Address 5 holds the trim code in bits 2:0. Addresses 6 and 7 read 0. Reads are combinational.
- R9: `trim_out` always equals the trim register. It changes only on a write to address 5.
- R10: The counter stays at 0 for the whole time `pwm_sync` is high, however long that is. Counting is therefore measured from the end of the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_sync | input | 1 | PWM synchronisation pulse; high while the ramp is being reset |
| cmp_in | input | 4 | Comparator outputs, bit 3 is the auxiliary channel |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| trim_out | output | 3 | Current-source trim code |

## Verification
A comparator edge passes through two synchroniser flops, and the capture flop then takes the counter value of the following cycle. A result therefore lands two edges after its input is first sampled high, and the bench predicts k+1, or half of that in slow mode. Published results become readable one cycle after the first edge that sees the pulse high. Writes become visible after the next edge. The bench drives inputs on falling edges and reads the combinational port 1 ns later. Each expected count is derived from the edge index at which the stimulus was applied, not from any internal state.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
   // Register map; result addresses follow the mode register in channel order
   localparam int unsigned ADDR_MODE     = 0;
   localparam int unsigned ADDR_RES_BASE = 1;
   // Bit of the mode register that selects full-rate counting
   localparam int unsigned MODE_FAST_BIT = 7;
endpackage

// File: rtl/adc_ramp_counter.sv
module adc_ramp_counter #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             fast_i,
   output logic [CNT_W-1:0] count_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("adc_ramp_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic             phase;
   logic [CNT_W-1:0] cnt;
   logic             step;

   assign step = fast_i | phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (sync_i) begin
         cnt   <= '0;
         phase <= 1'b0;
      end else if (cnt != CNT_MAX) begin
         phase <= fast_i ? 1'b0 : ~phase;
         if (step) cnt <= cnt + CNT_W'(1);
      end
   end

   assign count_o = cnt;

   // R10: discharge interval keeps the count at zero
   assert_hold_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (cnt == '0));
   // R4: ceiling is sticky until the next pulse
   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_MAX) && !sync_i |=> (cnt == CNT_MAX));
   // R2: full rate adds exactly one per clock below the ceiling
   assert_fast_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fast_i && !sync_i && (cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_W'(1)));
   // R3: half rate never adds more than one per clock
   assert_slow_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fast_i && !sync_i |=> ((cnt - $past(cnt)) <= CNT_W'(1)));
endmodule

// File: rtl/adc_capture_chan.sv
module adc_capture_chan #(
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic             cmp_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [CNT_W-1:0] stamp_o,
   output logic             hit_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_stages
         $error("adc_capture_chan: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] shreg;
   logic                   prev;
   logic                   rise;
   logic                   hit;
   logic [CNT_W-1:0]       stamp;

   assign rise = shreg[SYNC_STAGES-1] & ~prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         prev  <= 1'b0;
         hit   <= 1'b0;
         stamp <= '0;
      end else begin
         shreg <= {shreg[SYNC_STAGES-2:0], cmp_i};
         prev  <= shreg[SYNC_STAGES-1];
         if (sync_i) begin
            hit   <= 1'b0;
            stamp <= '0;
         end else if (rise && !hit) begin
            hit   <= 1'b1;
            stamp <= count_i;
         end
      end
   end

   assign stamp_o = stamp;
   assign hit_o   = hit;

   // R5: once tripped, the stamp is frozen for the rest of the cycle
   assert_first_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hit && !sync_i |=> ($stable(stamp) && hit));
   // R6: a channel without a trip carries a zero stamp
   assert_miss_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (stamp == '0));
endmodule

// File: rtl/adc_cap_regs.sv
module adc_cap_regs
   import adc_cap_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 12,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned TRIM_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sync_i,
   input  logic [NUM_CH*CNT_W-1:0] stamp_i,
   input  logic [NUM_CH-1:0]       hit_i,
   input  logic [ADDR_W-1:0]       addr_i,
   input  logic                    wr_i,
   input  logic [DATA_W-1:0]       wdata_i,
   output logic [DATA_W-1:0]       rdata_o,
   output logic                    fast_o,
   output logic [TRIM_W-1:0]       trim_o
);
   localparam int unsigned ADDR_TRIM = ADDR_RES_BASE + NUM_CH;
   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADDR_MODE);
   localparam logic [ADDR_W-1:0] A_TRIM = ADDR_W'(ADDR_TRIM);

   generate
      if (ADDR_TRIM >= (1 << ADDR_W)) begin : g_bad_addr
         $error("adc_cap_regs: address space too small for NUM_CH");
      end
      if (DATA_W <= MODE_FAST_BIT || DATA_W < CNT_W) begin : g_bad_data
         $error("adc_cap_regs: DATA_W too narrow");
      end
      if (TRIM_W >= MODE_FAST_BIT) begin : g_bad_trim
         $error("adc_cap_regs: TRIM_W overlaps the mode bit");
      end
   endgenerate

   logic              sync_d;
   logic              publish;
   logic              fast;
   logic [TRIM_W-1:0] trim;
   logic [CNT_W-1:0]  res [NUM_CH];
   logic              unused_wd;

   assign publish   = sync_i & ~sync_d;
   assign unused_wd = ^{wdata_i[DATA_W-1:MODE_FAST_BIT+1], wdata_i[MODE_FAST_BIT-1:TRIM_W]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_d <= 1'b0;
         fast   <= 1'b0;
         trim   <= '0;
      end else begin
         sync_d <= sync_i;
         if (wr_i && addr_i == A_MODE) fast <= wdata_i[MODE_FAST_BIT];
         if (wr_i && addr_i == A_TRIM) trim <= wdata_i[TRIM_W-1:0];
      end
   end

   genvar g;
   generate
      for (g = 0; g < NUM_CH; g++) begin : g_res
         always_ff @(posedge clk) begin
            if (!rst_n)       res[g] <= '0;
            else if (publish) res[g] <= hit_i[g] ? stamp_i[g*CNT_W +: CNT_W] : '0;
         end
         // R7: results move only on the first edge of a pulse
         assert_publish_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !publish |=> $stable(res[g]));
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_MODE) rdata_o[MODE_FAST_BIT] = fast;
      if (addr_i == A_TRIM) rdata_o[TRIM_W-1:0] = trim;
      for (int i = 0; i < int'(NUM_CH); i++) begin
         if (addr_i == ADDR_W'(ADDR_RES_BASE + i)) rdata_o = DATA_W'(res[i]);
      end
   end

   assign fast_o = fast;
   assign trim_o = trim;

   // R9: trim code changes only through its own address
   assert_trim_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && addr_i == A_TRIM) |=> $stable(trim_o));
   // R8: mode register reads back nothing but the rate bit
   assert_mode_bits_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_MODE) |-> ($countones(rdata_o) <= 1));
endmodule

// File: rtl/ramp_adc_capture.sv
module ramp_adc_capture #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CNT_W       = 12,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned TRIM_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwm_sync,
   input  logic [NUM_CH-1:0] cmp_in,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [TRIM_W-1:0] trim_out
);
   localparam int unsigned STAMP_W = NUM_CH * CNT_W;

   logic               fast;
   logic [CNT_W-1:0]   count;
   logic [STAMP_W-1:0] stamps;
   logic [NUM_CH-1:0]  hits;

   adc_ramp_counter #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (pwm_sync),
      .fast_i (fast),
      .count_o(count)
   );

   genvar c;
   generate
      for (c = 0; c < NUM_CH; c++) begin : g_ch
         adc_capture_chan #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_i (pwm_sync),
            .cmp_i  (cmp_in[c]),
            .count_i(count),
            .stamp_o(stamps[c*CNT_W +: CNT_W]),
            .hit_o  (hits[c])
         );
      end
   endgenerate

   adc_cap_regs #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .TRIM_W(TRIM_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .sync_i (pwm_sync),
      .stamp_i(stamps),
      .hit_i  (hits),
      .addr_i (reg_addr),
      .wr_i   (reg_wr),
      .wdata_i(reg_wdata),
      .rdata_o(reg_rdata),
      .fast_o (fast),
      .trim_o (trim_out)
   );
endmodule

// File: tb/sim_ramp_adc_capture.sv
`timescale 1ns/1ps
module sim_ramp_adc_capture;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwm_sync = 1'b0;
   logic [3:0]  cmp_in = '0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [2:0]  trim_out;

   int checks = 0;
   int failures = 0;
   int cur_k[4];
   int val;

   always #2.5 clk = ~clk;

   ramp_adc_capture u0 (
      .clk(clk), .rst_n(rst_n), .pwm_sync(pwm_sync), .cmp_in(cmp_in),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .trim_out(trim_out)
   );

   // fast, sync length, trip edges per channel (0 = none), expected results
   localparam int NV = 5;
   localparam int T_FAST[NV] = '{1, 0, 1, 0, 1};
   localparam int T_SYNC[NV] = '{3, 3, 20, 8, 2};
   localparam int T_K[NV*4]  = '{10, 20, 30, 0,   10, 21, 5, 40,   1, 2, 100, 300,
                                 0, 0, 0, 7,      398, 0, 50, 1};
   localparam int T_E[NV*4]  = '{11, 21, 31, 0,   5, 11, 3, 20,    2, 3, 101, 301,
                                 0, 0, 0, 4,      399, 0, 51, 2};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      @(negedge clk);
      reg_addr = 3'(a);
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      reg_addr = 3'(a); reg_wdata = 16'(d); reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   // One conversion cycle; leaves pwm_sync high after publishing
   task automatic run_conv(input int fast, input int synclen, input int hold);
      wr(0, fast ? 16'h0080 : 16'h0000);
      repeat (synclen) begin @(negedge clk); pwm_sync = 1'b1; end
      for (int n = 1; n <= hold; n++) begin
         if (n > 1) @(negedge clk);
         if (n == 1) pwm_sync = 1'b0;
         for (int c = 0; c < 4; c++) if (cur_k[c] == n) cmp_in[c] = 1'b1;
      end
      @(negedge clk);
      cmp_in = '0; pwm_sync = 1'b1;
      @(posedge clk);
   endtask

   initial begin
      #(5ns * 100000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 6; a++) begin rd(a, val); chk("R1 reset reg", val, 0); end
      chk("R1 trim_out", int'(trim_out), 0);

      // R8 / R9: register map
      wr(5, 5); rd(5, val); chk("R8 trim read", val, 5); chk("R9 trim_out", int'(trim_out), 5);
      wr(0, 16'hFFFF); rd(5, val); chk("R9 trim unchanged", int'(trim_out), 5);
      rd(0, val); chk("R8 mode only bit7", val, 16'h0080);
      wr(5, 16'hFFF7); chk("R9 trim low bits", int'(trim_out), 7);
      rd(6, val); chk("R8 addr6 zero", val, 0);
      rd(7, val); chk("R8 addr7 zero", val, 0);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         for (int c = 0; c < 4; c++) cur_k[c] = T_K[v*4+c];
         run_conv(T_FAST[v], T_SYNC[v], 400);
         for (int c = 0; c < 4; c++) begin
            rd(1 + c, val);
            if (T_K[v*4+c] == 0) chk("R6 no trip", val, 0);
            else if (T_SYNC[v] > 3) chk("R10 long sync", val, T_E[v*4+c]);
            else if (T_FAST[v] == 1) chk("R2 fast count", val, T_E[v*4+c]);
            else chk("R3 slow count", val, T_E[v*4+c]);
         end
      end

      // R8: results are read-only
      wr(1, 16'h0ABC); rd(1, val); chk("R8 result read-only", val, 399);

      // R5 / R6 / R7: toggles, pre-high input, mid-cycle stability
      wr(0, 16'h0080);
      @(negedge clk); pwm_sync = 1'b1; cmp_in[1] = 1'b1;
      repeat (3) @(negedge clk);
      reg_addr = 3'd1;
      for (int n = 1; n <= 400; n++) begin
         if (n > 1) @(negedge clk);
         if (n == 1) pwm_sync = 1'b0;
         if (n == 10) cmp_in[0] = 1'b1;
         if (n == 15) cmp_in[0] = 1'b0;
         if (n == 30) cmp_in[0] = 1'b1;
         if (n == 200) begin #1; chk("R7 stable mid-cycle", int'(reg_rdata), 399); end
      end
      @(negedge clk); cmp_in = '0; pwm_sync = 1'b1;
      @(posedge clk);
      rd(1, val); chk("R5 first edge only", val, 11);
      rd(2, val); chk("R6 high before count", val, 0);

      // R4: saturation, full rate
      cur_k = '{4093, 4094, 4150, 0};
      run_conv(1, 3, 4200);
      rd(1, val); chk("R4 below ceiling", val, 4094);
      rd(2, val); chk("R4 at ceiling", val, 4095);
      rd(3, val); chk("R4 clamped fast", val, 4095);

      // R4: saturation, half rate
      cur_k = '{8187, 8300, 0, 0};
      run_conv(0, 3, 8400);
      rd(1, val); chk("R4 slow below ceiling", val, 4094);
      rd(2, val); chk("R4 clamped slow", val, 4095);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule